// File: doc/BRIEF.md
# Two-Window Command Router for a Transmit/Receive Pair

This block takes read and write commands from one bus initiator and steers each one to one of two targets, a transmit unit and a receive unit, which share a 4 KB register window. The initiator may reach that window in two ways, picked per command by a 4-bit address-space qualifier. With space 0 it uses an absolute 32-bit address inside 0x3000_0000..0x3000_0FFF. With space 1 it uses a short configuration-port address in 0x000..0xFFF. Offsets below 0x800 belong to the transmit unit and offsets from 0x800 upward belong to the receive unit. The chosen target gets the command together with its 11-bit local offset. The other target sees an idle command with zeroed address and data. An address that fits neither window produces an error response, and no target is touched.

The command side follows valid/ready rules. A command counts as presented when `cmd_kind` is write (01) or read (10). It is accepted on a rising clock edge where `cmd_ready` is high, and it may not be withdrawn before then. A response comes out one clock after acceptance and stays on the pins unchanged until a cycle in which `rsp_ready` is high. While a response is stalled, `cmd_ready` is low, so a target never receives a second command before its previous result has been taken. Each target registers its read data on the edge that accepts a read. It must hold that data until it receives its next command.

Top module: `addr_router`

## Requirements
- R1: With `cmd_space` = 4'b0000, a command hits only if address bits [31:12] equal 0x30000.
- R2: With `cmd_space` = 4'b0001, a command hits only if address bits [31:12] are all zero.
- R3: Any `cmd_space` value other than 0000 and 0001 is a miss.
- R4: On a hit, address bit 11 = 0 selects the transmit target and bit 11 = 1 selects the receive target. The target receives address bits [10:0] and the write data.
- R5: An accepted command appears on at most one target's `*_cmd` pins. The other target's command is idle (00) with zero address and data. On a miss, both targets are idle.
- R6: Kind 00 (idle) and kind 11 (reserved) are neither forwarded nor answered.
- R7: A response is valid in the cycle after acceptance. A hit gives code 01 (accept). A miss gives code 11 (error) with zero data. The data of a write response is zero.
- R8: The read data of a response comes from the target that received the command, even when the next command goes to the other target.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the response stays stable, `cmd_ready` is low, and nothing is forwarded.
- R10: While `rst_n` is low, `rsp_valid` and `cmd_ready` are low and both targets see idle commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_kind | input | 2 | 00 idle, 01 write, 10 read, 11 reserved |
| cmd_space | input | 4 | Address-space qualifier |
| cmd_addr | input | 32 | Command address |
| cmd_wdata | input | 32 | Write data |
| cmd_ready | output | 1 | Command accepted when high with a write or read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Initiator takes the response |
| rsp_code | output | 2 | 01 accept, 11 error |
| rsp_rdata | output | 32 | Read data, zero on write or error |
| tx_cmd | output | 2 | Command to transmit target |
| tx_addr | output | 11 | Offset to transmit target |
| tx_wdata | output | 32 | Write data to transmit target |
| tx_rdata | input | 32 | Registered read data from transmit target |
| rx_cmd | output | 2 | Command to receive target |
| rx_addr | output | 11 | Offset to receive target |
| rx_wdata | output | 32 | Write data to receive target |
| rx_rdata | input | 32 | Registered read data from receive target |

## Verification
The bench builds the router with its default parameters: 32-bit addresses and data, a 4-bit qualifier, and a 12-bit window tagged 0x30000. With these values, both edges of each half are reachable: 0x7FC against 0x800, and 0xFFC against 0x1000. Addresses from one window can be offered under the other window's qualifier, and every unused qualifier code is reachable as well. The small target models answer from the offset they received. A response therefore shows which target took the command, which is what the back-to-back and stalled-response cases depend on.

// File: rtl/arouter_pkg.sv
package arouter_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE = 2'b00,
    CMD_WR   = 2'b01,
    CMD_RD   = 2'b10,
    CMD_RSV  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    RSP_NONE = 2'b00,
    RSP_OK   = 2'b01,
    RSP_ERR  = 2'b11
  } rsp_e;

  localparam int N_TGT  = 2;
  localparam int TGT_TX = 0;
  localparam int TGT_RX = 1;
endpackage

// File: rtl/arouter_decode.sv
module arouter_decode #(
  parameter int ADDR_W = 32,
  parameter int SPC_W  = 4,
  parameter int WIN_W  = 12,
  parameter logic [ADDR_W-WIN_W-1:0] ABS_TAG = 20'h30000,
  parameter logic [SPC_W-1:0] SPC_ABS = 4'h0,
  parameter logic [SPC_W-1:0] SPC_CFG = 4'h1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SPC_W-1:0]  space_i,
  output logic              hit_o,
  output logic              upper_o,
  output logic [WIN_W-2:0]  offset_o
);
  localparam int TAG_W = ADDR_W - WIN_W;

  logic [TAG_W-1:0] tag;
  assign tag = addr_i[ADDR_W-1:WIN_W];

  always_comb begin
    hit_o = 1'b0;
    if (space_i == SPC_ABS)      hit_o = (tag == ABS_TAG);
    else if (space_i == SPC_CFG) hit_o = (tag == '0);
  end

  assign upper_o  = addr_i[WIN_W-1];
  assign offset_o = addr_i[WIN_W-2:0];
endmodule

// File: rtl/arouter_fwd.sv
module arouter_fwd
  import arouter_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 11
) (
  input  logic              accept_i,
  input  logic              hit_i,
  input  logic              upper_i,
  input  logic [1:0]        kind_i,
  input  logic [OFS_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [1:0]        tgt_cmd_o   [N_TGT],
  output logic [OFS_W-1:0]  tgt_addr_o  [N_TGT],
  output logic [DATA_W-1:0] tgt_wdata_o [N_TGT]
);
  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    logic pick;
    assign pick = accept_i && hit_i && (upper_i == (g == TGT_RX));
    assign tgt_cmd_o[g]   = pick ? kind_i   : CMD_IDLE;
    assign tgt_addr_o[g]  = pick ? offset_i : '0;
    assign tgt_wdata_o[g] = pick ? wdata_i  : '0;
  end
endmodule

// File: rtl/arouter_rsp.sv
module arouter_rsp
  import arouter_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        kind_i,
  input  logic              hit_i,
  input  logic              upper_i,
  output logic              accept_o,
  output logic              cmd_ready_o,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [1:0]        rsp_code_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [DATA_W-1:0] tgt_rdata_i [N_TGT]
);
  logic valid_q, err_q, rd_q, sel_q;
  logic cmd_live;

  assign cmd_live    = (kind_i == CMD_WR) || (kind_i == CMD_RD);
  assign cmd_ready_o = rst_n && (!valid_q || rsp_ready_i);
  assign accept_o    = cmd_ready_o && cmd_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= 1'b0;
      sel_q   <= 1'b0;
    end else if (accept_o) begin
      valid_q <= 1'b1;
      err_q   <= !hit_i;
      rd_q    <= (kind_i == CMD_RD);
      sel_q   <= upper_i;
    end else if (valid_q && rsp_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign rsp_valid_o = valid_q;

  always_comb begin
    rsp_code_o  = RSP_NONE;
    rsp_rdata_o = '0;
    if (valid_q) begin
      rsp_code_o = err_q ? RSP_ERR : RSP_OK;
      if (!err_q && rd_q)
        rsp_rdata_o = sel_q ? tgt_rdata_i[TGT_RX] : tgt_rdata_i[TGT_TX];
    end
  end
endmodule

// File: rtl/addr_router.sv
module addr_router
  import arouter_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SPC_W  = 4,
  parameter int WIN_W  = 12,
  parameter logic [ADDR_W-WIN_W-1:0] ABS_TAG = 20'h30000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd_kind,
  input  logic [SPC_W-1:0]  cmd_space,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_ready,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        tx_cmd,
  output logic [WIN_W-2:0]  tx_addr,
  output logic [DATA_W-1:0] tx_wdata,
  input  logic [DATA_W-1:0] tx_rdata,
  output logic [1:0]        rx_cmd,
  output logic [WIN_W-2:0]  rx_addr,
  output logic [DATA_W-1:0] rx_wdata,
  input  logic [DATA_W-1:0] rx_rdata
);
  localparam int OFS_W = WIN_W - 1;

  logic             hit, upper, accept;
  logic [OFS_W-1:0] offset;
  logic [1:0]        t_cmd   [N_TGT];
  logic [OFS_W-1:0]  t_addr  [N_TGT];
  logic [DATA_W-1:0] t_wdata [N_TGT];
  logic [DATA_W-1:0] t_rdata [N_TGT];

  arouter_decode #(
    .ADDR_W(ADDR_W), .SPC_W(SPC_W), .WIN_W(WIN_W), .ABS_TAG(ABS_TAG)
  ) u_dec (
    .addr_i(cmd_addr), .space_i(cmd_space),
    .hit_o(hit), .upper_o(upper), .offset_o(offset)
  );

  arouter_fwd #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_fwd (
    .accept_i(accept), .hit_i(hit), .upper_i(upper), .kind_i(cmd_kind),
    .offset_i(offset), .wdata_i(cmd_wdata),
    .tgt_cmd_o(t_cmd), .tgt_addr_o(t_addr), .tgt_wdata_o(t_wdata)
  );

  assign t_rdata[TGT_TX] = tx_rdata;
  assign t_rdata[TGT_RX] = rx_rdata;

  arouter_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .kind_i(cmd_kind), .hit_i(hit), .upper_i(upper),
    .accept_o(accept), .cmd_ready_o(cmd_ready), .rsp_valid_o(rsp_valid),
    .rsp_ready_i(rsp_ready), .rsp_code_o(rsp_code), .rsp_rdata_o(rsp_rdata),
    .tgt_rdata_i(t_rdata)
  );

  assign tx_cmd   = t_cmd[TGT_TX];
  assign tx_addr  = t_addr[TGT_TX];
  assign tx_wdata = t_wdata[TGT_TX];
  assign rx_cmd   = t_cmd[TGT_RX];
  assign rx_addr  = t_addr[TGT_RX];
  assign rx_wdata = t_wdata[TGT_RX];
endmodule

// File: rtl/addr_router_chk.sv
module addr_router_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SPC_W  = 4,
  parameter int WIN_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cmd_kind,
  input logic [SPC_W-1:0]  cmd_space,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_code,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [1:0]        tx_cmd,
  input logic [1:0]        rx_cmd
);
  logic live, acc, tx_on, rx_on;
  assign live  = (cmd_kind == 2'b01) || (cmd_kind == 2'b10);
  assign acc   = cmd_ready && live;
  assign tx_on = (tx_cmd != 2'b00);
  assign rx_on = (rx_cmd != 2'b00);

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_on, rx_on})); // R5
  AST_CFG_HIGH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_space == 4'h1 && cmd_addr[ADDR_W-1:WIN_W] != '0) |-> !tx_on && !rx_on); // R2
  AST_BAD_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_space != 4'h0 && cmd_space != 4'h1) |-> !tx_on && !rx_on); // R3
  AST_RX_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    rx_on |-> cmd_addr[WIN_W-1]); // R4
  AST_NO_LIVE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    !live |-> !tx_on && !rx_on); // R6
  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R7
  AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'b11) |-> rsp_rdata == '0); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_code) && $stable(rsp_rdata)); // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready && !tx_on && !rx_on); // R9
endmodule

bind addr_router addr_router_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPC_W(SPC_W), .WIN_W(WIN_W)
) u_chk (.*);

// File: tb/test_addr_router.sv
`timescale 1ns/1ps
module test_addr_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_kind = 2'b00;
  logic [3:0]  cmd_space = 4'h0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_code, tx_cmd, rx_cmd;
  logic [31:0] rsp_rdata, tx_wdata, rx_wdata;
  logic [10:0] tx_addr, rx_addr;
  logic [31:0] tx_rdata = '0, rx_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_router i_addr_router (.*);

  // target models: registered read data tagged by target
  always_ff @(posedge clk) begin
    if (tx_cmd == 2'b10) tx_rdata <= 32'hA000_0000 | 32'(tx_addr);
    if (rx_cmd == 2'b10) rx_rdata <= 32'hB000_0000 | 32'(rx_addr);
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // {space[4], addr[32], kind[2], dest[2]}  dest: 0 tx, 1 rx, 2 miss
  localparam logic [39:0] VEC [12] = '{
    {4'h0, 32'h3000_0004, 2'b10, 2'd0},
    {4'h0, 32'h3000_0804, 2'b10, 2'd1},
    {4'h0, 32'h3000_07FC, 2'b01, 2'd0},
    {4'h0, 32'h3000_0FFC, 2'b01, 2'd1},
    {4'h0, 32'h3001_0000, 2'b10, 2'd2},
    {4'h0, 32'h0000_0800, 2'b10, 2'd2},
    {4'h1, 32'h0000_0010, 2'b10, 2'd0},
    {4'h1, 32'h0000_0FF0, 2'b10, 2'd1},
    {4'h1, 32'h0000_1000, 2'b01, 2'd2},
    {4'h1, 32'h3000_0000, 2'b10, 2'd2},
    {4'h2, 32'h0000_0100, 2'b10, 2'd2},
    {4'hF, 32'h3000_0800, 2'b01, 2'd2}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R10: reset state, even with a read offered
    cmd_kind = 2'b10; cmd_space = 4'h0; cmd_addr = 32'h3000_0004;
    repeat (3) @(negedge clk);
    chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R10 cmd_ready", 32'(cmd_ready), 32'd0);
    chk("R10 tx_cmd", 32'(tx_cmd), 32'd0);
    chk("R10 rx_cmd", 32'(rx_cmd), 32'd0);
    cmd_kind = 2'b00;
    rst_n = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < 12; i++) begin
      logic [3:0]  sp;
      logic [31:0] ad;
      logic [1:0]  kd, ds;
      logic [31:0] wd, expd;
      {sp, ad, kd, ds} = VEC[i];
      wd = 32'h5A00_0000 | 32'(i);
      cmd_space = sp; cmd_addr = ad; cmd_kind = kd; cmd_wdata = wd;
      #1;
      chk("R5 tx_cmd", 32'(tx_cmd), (ds == 2'd0) ? 32'(kd) : 32'd0);
      chk("R5 rx_cmd", 32'(rx_cmd), (ds == 2'd1) ? 32'(kd) : 32'd0);
      if (ds == 2'd0) begin
        chk("R4 tx_addr", 32'(tx_addr), 32'(ad[10:0]));
        chk("R4 tx_wdata", tx_wdata, wd);
      end
      if (ds == 2'd1) begin
        chk("R4 rx_addr", 32'(rx_addr), 32'(ad[10:0]));
        chk("R4 rx_wdata", rx_wdata, wd);
      end
      @(posedge clk);
      @(negedge clk);
      cmd_kind = 2'b00;
      chk("R7 rsp_valid", 32'(rsp_valid), 32'd1);
      chk((sp == 4'h0) ? "R1 rsp_code" : (sp == 4'h1) ? "R2 rsp_code" : "R3 rsp_code",
          32'(rsp_code), (ds == 2'd2) ? 32'd3 : 32'd1);
      if (ds == 2'd2 || kd == 2'b01) expd = 32'd0;
      else expd = ((ds == 2'd1) ? 32'hB000_0000 : 32'hA000_0000) | 32'(ad[10:0]);
      chk("R7 rsp_rdata", rsp_rdata, expd);
    end

    // R6: idle and reserved kinds
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      cmd_kind = (k == 0) ? 2'b00 : 2'b11;
      cmd_space = 4'h0; cmd_addr = 32'h3000_0810;
      #1;
      chk("R6 tx_cmd", 32'(tx_cmd), 32'd0);
      chk("R6 rx_cmd", 32'(rx_cmd), 32'd0);
      @(negedge clk);
      chk("R6 rsp_valid", 32'(rsp_valid), 32'd0);
    end

    // R8: back-to-back, tx read then rx read
    cmd_kind = 2'b10; cmd_space = 4'h0; cmd_addr = 32'h3000_0010;
    @(negedge clk);
    cmd_addr = 32'h3000_0820;
    #1;
    chk("R8 rsp_rdata first", rsp_rdata, 32'hA000_0010);
    chk("R8 rx fwd second", 32'(rx_cmd), 32'd2);
    @(negedge clk);
    cmd_kind = 2'b00;
    chk("R8 rsp_rdata second", rsp_rdata, 32'hB000_0020);
    @(negedge clk);

    // R9: stalled response
    rsp_ready = 1'b0;
    cmd_kind = 2'b10; cmd_space = 4'h1; cmd_addr = 32'h0000_0030;
    @(negedge clk);
    cmd_addr = 32'h0000_0840;
    #1;
    chk("R9 cmd_ready low", 32'(cmd_ready), 32'd0);
    chk("R9 rx idle", 32'(rx_cmd), 32'd0);
    @(negedge clk);
    chk("R9 rsp held valid", 32'(rsp_valid), 32'd1);
    chk("R9 rsp held data", rsp_rdata, 32'hA000_0030);
    rsp_ready = 1'b1;
    #1;
    chk("R9 rx fwd after release", 32'(rx_cmd), 32'd2);
    @(negedge clk);
    cmd_kind = 2'b00;
    chk("R9 next rsp data", rsp_rdata, 32'hB000_0040);
    @(negedge clk);
    chk("R9 drained", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule